// File: doc/BRIEF.md
# Coprocessor Register-Register ALU Execute Unit

This block executes the register-to-register form of a small coprocessor's ALU instruction. Each cycle it may be handed a 32-bit instruction word with a valid strobe. When the word is an ALU instruction of the register-register sub-type, the block reads two of four 16-bit general registers. It applies one of seven operations: add, subtract, bitwise AND, bitwise OR, copy, logical shift left and logical shift right. The result goes to a destination register. A sticky zero flag and a sticky overflow flag are updated from that result.

The register file and both flags live inside the block. A debug port reads any register at any time and can also write a register, which is how a host or a neighbouring load path seeds operand values. Any word that is not an executable register-register ALU instruction leaves every register and both flags as they were.

Top module: `cpalu_exec`

## Requirements
- R1: An instruction executes only when `instr_vld_i` is high, bits [31:28] equal 7 and bits [27:25] equal 0. Any other word, or a word without the strobe, changes no register and no flag.
- R2: Bits [24:21] hold the operation select. Bits [1:0] hold the destination index, bits [3:2] the first source index and bits [5:4] the second source index, each naming R0 to R3. Sources read the values held before the edge, even when a source is also the destination.
- R3: Select 0 (ADD) writes (src1 + src2) mod 2^16 and sets the overflow flag to the carry out of bit 15.
- R4: Select 1 (SUB) writes (src1 - src2) mod 2^16 and sets the overflow flag to 1 exactly when src1 < src2 unsigned.
- R5: Select 2 writes the bitwise AND of the sources and select 3 writes their bitwise OR.
- R6: Select 4 (MOVE) copies src1 to the destination.
- R7: Select 5 shifts src1 left and select 6 shifts it right, both logical with zero fill. The amount is the whole 16-bit value of src2, and an amount of 16 or more gives 0.
- R8: Every executed operation sets the zero flag to 1 when its result is 0 and clears it otherwise.
- R9: Selects 2 to 6 leave the overflow flag unchanged.
- R10: Selects 7 to 15 are reserved. They write no register and change neither flag.
- R11: Register and flag updates appear after the rising clock edge that samples the instruction, and not before it. A synchronous reset clears all four registers and both flags.
- R12: `dbg_rdata_o` shows the register named by `dbg_sel_i` combinationally. With `dbg_we_i` high, `dbg_wdata_i` is written to that register at the edge and the flags are left untouched. An executed instruction that writes the same register in the same cycle wins over the debug write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 32 | Instruction word |
| instr_vld_i | input | 1 | Instruction valid strobe |
| dbg_sel_i | input | 2 | Debug register index for read and write |
| dbg_we_i | input | 1 | Debug write enable |
| dbg_wdata_i | input | 16 | Debug write data |
| dbg_rdata_o | output | 16 | Register selected by `dbg_sel_i` |
| zero_o | output | 1 | Sticky zero flag |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench goes after the arithmetic edges. Carry out of bit 15 on an add that wraps to zero must set both flags, so a design that took overflow from the truncated sum would miss it. A subtract with a borrow must set overflow, and a design that used the signed sense would get it wrong. Shift amounts of exactly 16 and of 256 must give zero, which catches a shifter that truncates the amount to four bits and wraps. The bench also checks that logic operations keep a set overflow flag, that wrong opcodes, non-zero sub-types and reserved selects leave the state intact, and that a debug write to the same register in the same cycle loses to the instruction. It also checks that a source that is also the destination reads its old value.

// File: rtl/cpalu_pkg.sv
package cpalu_pkg;

   localparam int unsigned INSTR_W = 32;
   localparam int unsigned OPC_W   = 4;
   localparam int unsigned SUBT_W  = 3;
   localparam int unsigned SEL_W   = 4;
   localparam int unsigned IDX_W   = 2;
   localparam int unsigned NREG    = 1 << IDX_W;

   // field positions are fixed by the instruction encoding
   localparam int unsigned OPC_LSB  = 28;
   localparam int unsigned SUBT_LSB = 25;
   localparam int unsigned SEL_LSB  = 21;
   localparam int unsigned DST_LSB  = 0;
   localparam int unsigned SRC1_LSB = 2;
   localparam int unsigned SRC2_LSB = 4;

   typedef enum logic [SEL_W-1:0] {
      SEL_ADD  = 4'd0,
      SEL_SUB  = 4'd1,
      SEL_AND  = 4'd2,
      SEL_OR   = 4'd3,
      SEL_MOVE = 4'd4,
      SEL_LSH  = 4'd5,
      SEL_RSH  = 4'd6
   } alu_sel_e;

   typedef struct packed {
      logic             exec;
      logic             arith;
      alu_sel_e         sel;
      logic [IDX_W-1:0] dst;
      logic [IDX_W-1:0] src1;
      logic [IDX_W-1:0] src2;
   } alu_dec_t;

   function automatic logic sel_defined(input logic [SEL_W-1:0] s);
      return s <= SEL_W'(SEL_RSH);
   endfunction

endpackage

// File: rtl/cpalu_decode.sv
module cpalu_decode
   import cpalu_pkg::*;
#(
   parameter int unsigned ALU_OPCODE = 7
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic               vld,
   output alu_dec_t           dec
);

   logic [OPC_W-1:0]  opc;
   logic [SUBT_W-1:0] subt;
   logic [SEL_W-1:0]  sel_raw;
   logic              unused_mid;

   assign opc        = instr[OPC_LSB  +: OPC_W];
   assign subt       = instr[SUBT_LSB +: SUBT_W];
   assign sel_raw    = instr[SEL_LSB  +: SEL_W];
   assign unused_mid = ^instr[SEL_LSB-1:SRC2_LSB+IDX_W];

   always_comb begin
      dec       = '0;
      dec.sel   = alu_sel_e'(sel_raw);
      dec.dst   = instr[DST_LSB  +: IDX_W];
      dec.src1  = instr[SRC1_LSB +: IDX_W];
      dec.src2  = instr[SRC2_LSB +: IDX_W];
      dec.exec  = vld && (opc == OPC_W'(ALU_OPCODE)) && (subt == '0)
                  && sel_defined(sel_raw);
      dec.arith = (sel_raw == SEL_W'(SEL_ADD)) || (sel_raw == SEL_W'(SEL_SUB));
   end

endmodule

// File: rtl/cpalu_shift.sv
module cpalu_shift #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned STAGED = 1
) (
   input  logic [DATA_W-1:0] val,
   input  logic [DATA_W-1:0] amt,
   input  logic              left,
   output logic [DATA_W-1:0] res
);

   localparam int unsigned SHW = $clog2(DATA_W);

   logic              over;
   logic [DATA_W-1:0] shifted;

   // any bit at or above SHW means the amount reaches the full width
   assign over = |amt[DATA_W-1:SHW];

   generate
      if (STAGED == 0) begin : g_flat
         assign shifted = left ? (val << amt[SHW-1:0]) : (val >> amt[SHW-1:0]);
      end else begin : g_log
         logic [DATA_W-1:0] stg [SHW+1];
         assign stg[0] = val;
         for (genvar k = 0; k < SHW; k++) begin : g_stage
            assign stg[k+1] = !amt[k] ? stg[k]
                            : left    ? (stg[k] << (2**k))
                                      : (stg[k] >> (2**k));
         end
         assign shifted = stg[SHW];
      end
   endgenerate

   assign res = over ? '0 : shifted;

endmodule

// File: rtl/cpalu_datapath.sv
module cpalu_datapath
   import cpalu_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned STAGED = 1
) (
   input  alu_sel_e          sel,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res,
   output logic              ovf
);

   logic [DATA_W:0]   sum_x;
   logic [DATA_W:0]   dif_x;
   logic [DATA_W-1:0] sh_res;

   // one extra bit holds the carry for ADD and the borrow for SUB
   assign sum_x = {1'b0, a} + {1'b0, b};
   assign dif_x = {1'b0, a} - {1'b0, b};

   cpalu_shift #(
      .DATA_W (DATA_W),
      .STAGED (STAGED)
   ) u_shift (
      .val  (a),
      .amt  (b),
      .left (sel == SEL_LSH),
      .res  (sh_res)
   );

   always_comb begin
      res = '0;
      ovf = 1'b0;
      unique case (sel)
         SEL_ADD:  begin res = sum_x[DATA_W-1:0]; ovf = sum_x[DATA_W]; end
         SEL_SUB:  begin res = dif_x[DATA_W-1:0]; ovf = dif_x[DATA_W]; end
         SEL_AND:  res = a & b;
         SEL_OR:   res = a | b;
         SEL_MOVE: res = a;
         SEL_LSH,
         SEL_RSH:  res = sh_res;
         default:  res = '0;
      endcase
   end

endmodule

// File: rtl/cpalu_regfile.sv
module cpalu_regfile
   import cpalu_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   wr_en,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic                   ovf_en,
   input  logic                   ovf_val,
   input  logic [IDX_W-1:0]       rd_a_idx,
   input  logic [IDX_W-1:0]       rd_b_idx,
   output logic [DATA_W-1:0]      rd_a,
   output logic [DATA_W-1:0]      rd_b,
   input  logic                   dbg_we,
   input  logic [IDX_W-1:0]       dbg_idx,
   input  logic [DATA_W-1:0]      dbg_wdata,
   output logic [DATA_W-1:0]      dbg_rdata,
   output logic [NREG*DATA_W-1:0] flat,
   output logic                   zero_q,
   output logic                   ovf_q
);

   logic [DATA_W-1:0] regs [NREG];

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               regs[i] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
               regs[i] <= wr_data;
            end else if (dbg_we && dbg_idx == IDX_W'(i)) begin
               regs[i] <= dbg_wdata;
            end
         end
         assign flat[i*DATA_W +: DATA_W] = regs[i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         zero_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else if (wr_en) begin
         zero_q <= (wr_data == '0);
         if (ovf_en) begin
            ovf_q <= ovf_val;
         end
      end
   end

   assign rd_a      = regs[rd_a_idx];
   assign rd_b      = regs[rd_b_idx];
   assign dbg_rdata = regs[dbg_idx];

endmodule

// File: rtl/cpalu_exec.sv
module cpalu_exec
   import cpalu_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ALU_OPCODE = 7,
   parameter int unsigned STAGED     = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [31:0]  instr_i,
   input  logic         instr_vld_i,
   input  logic [1:0]   dbg_sel_i,
   input  logic         dbg_we_i,
   input  logic [DATA_W-1:0] dbg_wdata_i,
   output logic [DATA_W-1:0] dbg_rdata_o,
   output logic         zero_o,
   output logic         ovf_o
);

   localparam int unsigned SHW = $clog2(DATA_W);

   generate
      if (DATA_W < 4 || (1 << SHW) != DATA_W) begin : g_bad_width
         $error("cpalu_exec: DATA_W must be a power of two of at least 4");
      end
      if (ALU_OPCODE >= (1 << OPC_W)) begin : g_bad_opc
         $error("cpalu_exec: ALU_OPCODE does not fit the opcode field");
      end
      if (STAGED > 1) begin : g_bad_style
         $error("cpalu_exec: STAGED selects 0 (flat) or 1 (log stages)");
      end
   endgenerate

   alu_dec_t                 dec;
   logic [DATA_W-1:0]        op_a;
   logic [DATA_W-1:0]        op_b;
   logic [DATA_W-1:0]        alu_res;
   logic                     alu_ovf;
   logic [NREG*DATA_W-1:0]   rf_flat;

   cpalu_decode #(
      .ALU_OPCODE (ALU_OPCODE)
   ) u_dec (
      .instr (instr_i),
      .vld   (instr_vld_i),
      .dec   (dec)
   );

   cpalu_datapath #(
      .DATA_W (DATA_W),
      .STAGED (STAGED)
   ) u_dp (
      .sel (dec.sel),
      .a   (op_a),
      .b   (op_b),
      .res (alu_res),
      .ovf (alu_ovf)
   );

   cpalu_regfile #(
      .DATA_W (DATA_W)
   ) u_rf (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (dec.exec),
      .wr_idx    (dec.dst),
      .wr_data   (alu_res),
      .ovf_en    (dec.arith),
      .ovf_val   (alu_ovf),
      .rd_a_idx  (dec.src1),
      .rd_b_idx  (dec.src2),
      .rd_a      (op_a),
      .rd_b      (op_b),
      .dbg_we    (dbg_we_i),
      .dbg_idx   (dbg_sel_i),
      .dbg_wdata (dbg_wdata_i),
      .dbg_rdata (dbg_rdata_o),
      .flat      (rf_flat),
      .zero_q    (zero_o),
      .ovf_q     (ovf_o)
   );

endmodule

// File: rtl/cpalu_exec_chk.sv
module cpalu_exec_chk #(
   parameter int unsigned DATA_W = 16
) (
   input logic                  clk,
   input logic                  rst,
   input logic [31:0]           instr_i,
   input logic                  instr_vld_i,
   input logic                  dbg_we_i,
   input logic                  zero_o,
   input logic                  ovf_o,
   input logic [4*DATA_W-1:0]   rf_flat
);

   logic is_alu;
   logic run;

   assign is_alu = instr_vld_i && instr_i[31:28] == 4'd7 && instr_i[27:25] == 3'd0;
   assign run    = is_alu && instr_i[24:21] <= 4'd6;

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!is_alu && !dbg_we_i) |=> ($stable(rf_flat) && $stable(zero_o) && $stable(ovf_o))); // R1

   AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
      (is_alu && instr_i[24:21] >= 4'd7 && !dbg_we_i)
      |=> ($stable(rf_flat) && $stable(zero_o) && $stable(ovf_o))); // R10

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (run && instr_i[24:21] >= 4'd2) |=> $stable(ovf_o)); // R9

   AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (rst)
      run |=> (zero_o == (rf_flat[$past(instr_i[1:0])*DATA_W +: DATA_W] == '0))); // R8

   AST_MOVE_COPY: assert property (@(posedge clk) disable iff (rst)
      (run && instr_i[24:21] == 4'd4)
      |=> (rf_flat[$past(instr_i[1:0])*DATA_W +: DATA_W]
           == $past(rf_flat[instr_i[3:2]*DATA_W +: DATA_W]))); // R6

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (rf_flat == '0 && !zero_o && !ovf_o)); // R11

endmodule

bind cpalu_exec cpalu_exec_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .instr_i     (instr_i),
   .instr_vld_i (instr_vld_i),
   .dbg_we_i    (dbg_we_i),
   .zero_o      (zero_o),
   .ovf_o       (ovf_o),
   .rf_flat     (rf_flat)
);

// File: tb/tb_cpalu_exec.sv
module tb_cpalu_exec;

   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] instr_i;
   logic        instr_vld_i;
   logic [1:0]  dbg_sel_i;
   logic        dbg_we_i;
   logic [15:0] dbg_wdata_i;
   logic [15:0] dbg_rdata_o;
   logic        zero_o;
   logic        ovf_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   cpalu_exec dut (
      .clk         (clk),
      .rst         (rst),
      .instr_i     (instr_i),
      .instr_vld_i (instr_vld_i),
      .dbg_sel_i   (dbg_sel_i),
      .dbg_we_i    (dbg_we_i),
      .dbg_wdata_i (dbg_wdata_i),
      .dbg_rdata_o (dbg_rdata_o),
      .zero_o      (zero_o),
      .ovf_o       (ovf_o)
   );

   // {sel, src1, src2, result, zero, ovf}; ovf column is the flag after the step
   localparam int NV = 16;
   localparam logic [53:0] VEC [NV] = '{
      {4'd0, 16'h1234, 16'h0001, 16'h1235, 1'b0, 1'b0},
      {4'd0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b1},
      {4'd0, 16'h8000, 16'h8000, 16'h0000, 1'b1, 1'b1},
      {4'd1, 16'h0005, 16'h0003, 16'h0002, 1'b0, 1'b0},
      {4'd1, 16'h7777, 16'h7777, 16'h0000, 1'b1, 1'b0},
      {4'd1, 16'h0003, 16'h0005, 16'hFFFE, 1'b0, 1'b1},
      {4'd2, 16'hF0F0, 16'h0FF0, 16'h00F0, 1'b0, 1'b1},
      {4'd2, 16'hAAAA, 16'h5555, 16'h0000, 1'b1, 1'b1},
      {4'd3, 16'hA000, 16'h0005, 16'hA005, 1'b0, 1'b1},
      {4'd4, 16'hBEEF, 16'h1111, 16'hBEEF, 1'b0, 1'b1},
      {4'd5, 16'h0001, 16'h0004, 16'h0010, 1'b0, 1'b1},
      {4'd5, 16'h8001, 16'h0001, 16'h0002, 1'b0, 1'b1},
      {4'd5, 16'h1234, 16'h0010, 16'h0000, 1'b1, 1'b1},
      {4'd6, 16'h8000, 16'h000F, 16'h0001, 1'b0, 1'b1},
      {4'd6, 16'hFFFF, 16'h0100, 16'h0000, 1'b1, 1'b1},
      {4'd6, 16'hF000, 16'h0004, 16'h0F00, 1'b0, 1'b1}
   };

   function automatic logic [31:0] mk(input logic [3:0] opc, input logic [2:0] subt,
                                      input logic [3:0] sel, input logic [1:0] d,
                                      input logic [1:0] s1, input logic [1:0] s2);
      return {opc, subt, sel, 15'd0, s2, s1, d};
   endfunction

   function automatic string req_of(input logic [3:0] sel);
      case (sel)
         4'd0:        return "R3";
         4'd1:        return "R4";
         4'd2, 4'd3:  return "R5";
         4'd4:        return "R6";
         default:     return "R7";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; instr_vld_i = 1'b0; dbg_we_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic dwrite(input logic [1:0] idx, input logic [15:0] val);
      @(negedge clk);
      dbg_we_i = 1'b1; dbg_sel_i = idx; dbg_wdata_i = val;
      @(negedge clk);
      dbg_we_i = 1'b0;
   endtask

   task automatic issue(input logic [31:0] w, input logic v);
      @(negedge clk);
      instr_i = w; instr_vld_i = v;
      @(negedge clk);
      instr_vld_i = 1'b0;
   endtask

   task automatic rd(input logic [1:0] idx, output logic [15:0] val);
      dbg_sel_i = idx;
      #1;
      val = dbg_rdata_o;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      logic [15:0] r0_old, r3_old;
      rst = 1'b1; instr_i = '0; instr_vld_i = 1'b0;
      dbg_sel_i = '0; dbg_we_i = 1'b0; dbg_wdata_i = '0;
      do_reset();

      // R11: reset state
      for (int i = 0; i < 4; i++) begin
         rd(2'(i), v);
         check("R11", "register after reset", v, 16'h0000);
      end
      check("R11", "zero flag after reset", {15'd0, zero_o}, 16'd0);
      check("R11", "ovf flag after reset", {15'd0, ovf_o}, 16'd0);

      // table walk: R1 <- src1, R2 <- src2, R3 <- op(R1, R2)
      for (int k = 0; k < NV; k++) begin
         logic [3:0]  sel;
         logic [15:0] a, b, res;
         logic        ez, eo;
         {sel, a, b, res, ez, eo} = VEC[k];
         dwrite(2'd1, a);
         dwrite(2'd2, b);
         issue(mk(4'd7, 3'd0, sel, 2'd3, 2'd1, 2'd2), 1'b1);
         rd(2'd3, v);
         check(req_of(sel), $sformatf("result of vector %0d", k), v, res);
         check("R8", $sformatf("zero flag of vector %0d", k), {15'd0, zero_o}, {15'd0, ez});
         check(sel < 4'd2 ? req_of(sel) : "R9",
               $sformatf("ovf flag of vector %0d", k), {15'd0, ovf_o}, {15'd0, eo});
      end
      // state now: R1=F000 R2=0004 R3=0F00 zero=0 ovf=1

      // R1: wrong opcode, non-zero sub-type, strobe low
      issue(mk(4'd6, 3'd0, 4'd0, 2'd3, 2'd1, 2'd2), 1'b1);
      rd(2'd3, v);
      check("R1", "wrong opcode keeps R3", v, 16'h0F00);
      issue(mk(4'd7, 3'd1, 4'd1, 2'd3, 2'd1, 2'd2), 1'b1);
      rd(2'd3, v);
      check("R1", "sub-type 1 keeps R3", v, 16'h0F00);
      issue(mk(4'd7, 3'd0, 4'd2, 2'd3, 2'd1, 2'd2), 1'b0);
      rd(2'd3, v);
      check("R1", "no strobe keeps R3", v, 16'h0F00);
      check("R1", "flags kept", {14'd0, zero_o, ovf_o}, 16'd1);

      // R10: reserved selects 7 and 15
      issue(mk(4'd7, 3'd0, 4'd7, 2'd3, 2'd1, 2'd2), 1'b1);
      rd(2'd3, v);
      check("R10", "select 7 keeps R3", v, 16'h0F00);
      issue(mk(4'd7, 3'd0, 4'd15, 2'd3, 2'd2, 2'd2), 1'b1);
      rd(2'd3, v);
      check("R10", "select 15 keeps R3", v, 16'h0F00);
      check("R10", "flags kept", {14'd0, zero_o, ovf_o}, 16'd1);

      // R2: other field placement, R0 = R2 - R1 = 0004 - F000 = 1004 with borrow
      issue(mk(4'd7, 3'd0, 4'd1, 2'd0, 2'd2, 2'd1), 1'b1);
      rd(2'd0, v);
      check("R2", "R0 = R2 - R1", v, 16'h1004);
      check("R2", "borrow flag", {15'd0, ovf_o}, 16'd1);
      rd(2'd1, v);
      check("R2", "source R1 untouched", v, 16'hF000);
      // R2: source equals destination, R2 = R2 + R2 = 0008
      issue(mk(4'd7, 3'd0, 4'd0, 2'd2, 2'd2, 2'd2), 1'b1);
      rd(2'd2, v);
      check("R2", "R2 = R2 + R2", v, 16'h0008);
      check("R3", "no carry", {15'd0, ovf_o}, 16'd0);

      // R11: update only after the edge
      rd(2'd0, r0_old);
      @(negedge clk);
      instr_i = mk(4'd7, 3'd0, 4'd4, 2'd0, 2'd2, 2'd2); instr_vld_i = 1'b1;
      rd(2'd0, v);
      check("R11", "R0 unchanged before edge", v, r0_old);
      @(negedge clk);
      instr_vld_i = 1'b0;
      rd(2'd0, v);
      check("R11", "R0 after edge", v, 16'h0008);

      // R12: debug write does not touch flags; instruction wins a collision
      dwrite(2'd3, 16'h0000);
      rd(2'd3, v);
      check("R12", "debug write lands", v, 16'h0000);
      check("R12", "flags untouched by debug write", {14'd0, zero_o, ovf_o}, 16'd0);
      @(negedge clk);
      dbg_we_i = 1'b1; dbg_sel_i = 2'd3; dbg_wdata_i = 16'h5555;
      instr_i = mk(4'd7, 3'd0, 4'd3, 2'd3, 2'd1, 2'd2); instr_vld_i = 1'b1;
      @(negedge clk);
      dbg_we_i = 1'b0; instr_vld_i = 1'b0;
      rd(2'd3, r3_old);
      check("R12", "instruction wins collision", r3_old, 16'hF008);

      // R11: reset mid-run clears everything
      issue(mk(4'd7, 3'd0, 4'd1, 2'd1, 2'd2, 2'd1), 1'b1); // 0008 - F000 borrows
      check("R4", "borrow before reset", {15'd0, ovf_o}, 16'd1);
      do_reset();
      for (int i = 0; i < 4; i++) begin
         rd(2'(i), v);
         check("R11", "register after second reset", v, 16'h0000);
      end
      check("R11", "flags after second reset", {14'd0, zero_o, ovf_o}, 16'd0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule